// File: doc/BRIEF.md
# Float-to-Unsigned-Integer Converter

This block turns a packed binary floating-point word into an unsigned integer in a single combinational path. The total width, exponent width and output width of the float are parameters. The rounding rule is fixed at elaboration by a one-hot parameter, so each instance carries exactly one rounding rule and no mode input. Typical use is inside a wider arithmetic unit that needs a float-to-index or float-to-count cast with a predictable result for every input pattern.

The input float uses a conventional layout:
- the sign is in the top bit;
- a biased exponent sits below the sign;
- the fraction sits in the low bits.

Zeros, subnormals, infinities and NaNs all give defined results. The block raises no flags. When the true result cannot be represented, the output is replaced by a default that depends only on the input sign:
- all zeros for a negative input;
- all ones otherwise.

Top module: `fltToUint`

## Requirements
- R1: Parameters FLT_W (default 32), EXP_W (default 8, 2 <= EXP_W <= FLT_W-2) and INT_W (default 32) set the layout. The sign is bit FLT_W-1. The exponent field, biased by 2^(EXP_W-1)-1, lies directly below the sign. The fraction occupies the low FLT_W-EXP_W-1 bits. The significand is FLT_W-EXP_W bits including the hidden bit. A positive input that is an exact integer below 2^INT_W appears unchanged on the output.
- R2: An all-ones exponent with a zero fraction (infinity) gives all ones when the sign bit is clear and all zeros when it is set.
- R3: An all-ones exponent with a nonzero fraction (NaN) gives all ones when the sign bit is clear and all zeros when it is set.
- R4: A positive finite input whose rounded value is at least 2^INT_W gives all ones. This includes the case where rounding carries out of the top bit, for example 255.5 with INT_W=8 under ties-to-even or ties-to-away.
- R5: A negative input whose rounded magnitude is nonzero is out of range and gives all zeros.
- R6: A negative input whose rounded magnitude is zero is a valid result and gives 0. Examples are -0.3 under toward-zero or to-nearest rounding.
- R7: Both zeros give 0. Subnormal inputs give 0, except that a positive subnormal gives 1 under toward-positive rounding.
- R8: RMODE = 5'b00001 selects round to nearest, ties to even. A fraction of exactly one half goes to the even neighbour (2.5 -> 2, 3.5 -> 4). Above one half rounds up; below one half rounds down.
- R9: RMODE = 5'b00010 selects round to nearest, ties away from zero (2.5 -> 3, 0.5 -> 1).
- R10: RMODE = 5'b00100 rounds toward positive infinity (2.1 -> 3). RMODE = 5'b01000 rounds toward negative infinity (2.9 -> 2). RMODE = 5'b10000 rounds toward zero (2.9 -> 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fltIn | input | FLT_W | Packed floating-point operand |
| intOut | output | INT_W | Unsigned integer result, or the sign-selected default |

## Verification
The bench builds five instances with FLT_W=16, EXP_W=5 and INT_W=8, one for each rounding code, plus one instance at the default 32/8/32 with ties-to-even.

The eight-bit output places overflow and the rounding carry past 255 close to ordinary values. The 16-bit input is small enough to sweep every pattern through all five rounding rules against a real-number model.

The default-width instance covers the single-precision layout at large values, including the largest float below 2^32 and 2^32 itself.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

  // One-hot rounding codes; bit position m selects rule m.
  localparam logic [4:0] RM_NEAR_EVEN = 5'b00001;
  localparam logic [4:0] RM_NEAR_AWAY = 5'b00010;
  localparam logic [4:0] RM_UP        = 5'b00100;
  localparam logic [4:0] RM_DOWN      = 5'b01000;
  localparam logic [4:0] RM_ZERO      = 5'b10000;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic useDefault;   // replace the result by the sign default
    logic defaultOnes;  // default is all ones (else all zeros)
    logic roundUp;      // add one to the truncated magnitude
  } f2uStrobes_t;

endpackage

// File: rtl/f2u_align.sv
module f2u_align #(
  parameter int FLT_W = 32,
  parameter int EXP_W = 8,
  parameter int INT_W = 32
) (
  input  logic [FLT_W-1:0] fltIn,
  output logic             signBit,
  output logic             expAllOnes,
  output logic             preOverflow,
  output logic             roundBit,
  output logic             stickyBit,
  output logic             magLsb,
  output logic             magAllOnes,
  output logic             magNonZero,
  output logic [INT_W-1:0] magnitude
);

  localparam int FRAC_W = FLT_W - EXP_W - 1;
  localparam int SIG_W  = FLT_W - EXP_W;
  localparam int MW     = INT_W + SIG_W;
  localparam int XW     = 2 * SIG_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int DW     = EXP_W + $clog2(MW + XW) + 2;

  logic [EXP_W-1:0]     expField;
  logic [FRAC_W-1:0]    fracField;
  logic [SIG_W-1:0]     sig;
  logic signed [DW-1:0] effExp;
  logic signed [DW-1:0] lsbExp;
  logic [DW-1:0]        rightAmt;
  logic [XW-1:0]        ext;
  logic [MW-1:0]        magWide;

  always_comb begin
    expField   = fltIn[FLT_W-2 -: EXP_W];
    fracField  = fltIn[FRAC_W-1:0];
    signBit    = fltIn[FLT_W-1];
    expAllOnes = &expField;
    sig        = {|expField, fracField};
    // Subnormals share the weight of the smallest normal exponent.
    effExp     = (|expField) ? signed'(DW'(expField)) : signed'(DW'(1));
    // Weight (power of two) of the significand LSB.
    lsbExp     = effExp - signed'(DW'(BIAS + FRAC_W));

    rightAmt    = '0;
    ext         = '0;
    magWide     = '0;
    roundBit    = 1'b0;
    stickyBit   = 1'b0;
    preOverflow = 1'b0;

    if (!lsbExp[DW-1]) begin
      // Integer-valued: shift left, no fraction bits remain.
      if (lsbExp >= signed'(DW'(INT_W))) begin
        preOverflow = |sig;
      end else begin
        magWide     = MW'(sig) << $unsigned(lsbExp);
        preOverflow = |magWide[MW-1:INT_W];
      end
    end else begin
      // Fractional part present: shift right, keep round and sticky.
      rightAmt = $unsigned(-lsbExp);
      if (rightAmt > DW'(SIG_W + 1)) rightAmt = DW'(SIG_W + 1);
      ext         = {sig, {(SIG_W + 1){1'b0}}} >> rightAmt;
      magWide     = MW'(ext[XW-1:SIG_W+1]);
      roundBit    = ext[SIG_W];
      stickyBit   = |ext[SIG_W-1:0];
      preOverflow = |magWide[MW-1:INT_W];
    end

    magnitude  = magWide[INT_W-1:0];
    magLsb     = magWide[0];
    magAllOnes = &magWide[INT_W-1:0];
    magNonZero = |magWide[INT_W-1:0];
  end

endmodule

// File: rtl/f2u_ctrl.sv
module f2u_ctrl
  import f2u_pkg::*;
#(
  parameter logic [4:0] RMODE = RM_NEAR_EVEN
) (
  input  logic        signBit,
  input  logic        expAllOnes,
  input  logic        preOverflow,
  input  logic        roundBit,
  input  logic        stickyBit,
  input  logic        magLsb,
  input  logic        magAllOnes,
  input  logic        magNonZero,
  output f2uStrobes_t strobes
);

  logic inexact;
  logic incr;
  logic carryOut;
  logic resultNonZero;

  always_comb begin
    inexact = roundBit | stickyBit;
    case (RMODE)
      RM_NEAR_EVEN: incr = roundBit & (stickyBit | magLsb);
      RM_NEAR_AWAY: incr = roundBit;
      RM_UP:        incr = ~signBit & inexact;
      RM_DOWN:      incr = signBit & inexact;
      default:      incr = 1'b0;
    endcase

    carryOut      = incr & magAllOnes;
    resultNonZero = magNonZero | incr;

    strobes.roundUp     = incr;
    strobes.defaultOnes = ~signBit;
    strobes.useDefault  = expAllOnes | preOverflow | carryOut |
                          (signBit & resultNonZero);
  end

endmodule

// File: rtl/f2u_finish.sv
module f2u_finish
  import f2u_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] magnitude,
  input  f2uStrobes_t      strobes,
  output logic [INT_W-1:0] intOut
);

  logic [INT_W-1:0] rounded;

  always_comb begin
    rounded = magnitude + INT_W'(strobes.roundUp);
    if (strobes.useDefault)
      intOut = strobes.defaultOnes ? {INT_W{1'b1}} : {INT_W{1'b0}};
    else
      intOut = rounded;
  end

endmodule

// File: rtl/fltToUint.sv
module fltToUint
  import f2u_pkg::*;
#(
  parameter int         FLT_W = 32,
  parameter int         EXP_W = 8,
  parameter int         INT_W = 32,
  parameter logic [4:0] RMODE = RM_NEAR_EVEN
) (
  input  logic [FLT_W-1:0] fltIn,
  output logic [INT_W-1:0] intOut
);

  logic             signBit;
  logic             expAllOnes;
  logic             preOverflow;
  logic             roundBit;
  logic             stickyBit;
  logic             magLsb;
  logic             magAllOnes;
  logic             magNonZero;
  logic [INT_W-1:0] magnitude;
  f2uStrobes_t      strobes;

  f2u_align #(.FLT_W(FLT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_align (
    .fltIn      (fltIn),
    .signBit    (signBit),
    .expAllOnes (expAllOnes),
    .preOverflow(preOverflow),
    .roundBit   (roundBit),
    .stickyBit  (stickyBit),
    .magLsb     (magLsb),
    .magAllOnes (magAllOnes),
    .magNonZero (magNonZero),
    .magnitude  (magnitude)
  );

  f2u_ctrl #(.RMODE(RMODE)) u_ctrl (
    .signBit    (signBit),
    .expAllOnes (expAllOnes),
    .preOverflow(preOverflow),
    .roundBit   (roundBit),
    .stickyBit  (stickyBit),
    .magLsb     (magLsb),
    .magAllOnes (magAllOnes),
    .magNonZero (magNonZero),
    .strobes    (strobes)
  );

  f2u_finish #(.INT_W(INT_W)) u_finish (
    .magnitude(magnitude),
    .strobes  (strobes),
    .intOut   (intOut)
  );

endmodule

// File: rtl/f2u_checker.sv
module f2u_checker #(
  parameter int FLT_W = 32,
  parameter int EXP_W = 8,
  parameter int INT_W = 32
) (
  input logic [FLT_W-1:0] fltIn,
  input logic [INT_W-1:0] intOut
);

  localparam int FRAC_W = FLT_W - EXP_W - 1;

  logic expOnes;
  logic expZero;
  logic fracAny;
  logic negIn;

  always_comb begin
    expOnes = &fltIn[FLT_W-2 -: EXP_W];
    expZero = ~|fltIn[FLT_W-2 -: EXP_W];
    fracAny = |fltIn[FRAC_W-1:0];
    negIn   = fltIn[FLT_W-1];

    // R2
    inf_default_chk: assert (!(expOnes && !fracAny && !negIn) || (&intOut));
    // R3
    nan_default_chk: assert (!(expOnes && fracAny && !negIn) || (&intOut));
    // R5
    neg_default_chk: assert (!negIn || (intOut == '0));
    // R7
    zero_input_chk: assert (!(expZero && !fracAny) || (intOut == '0));
  end

endmodule

bind fltToUint f2u_checker #(.FLT_W(FLT_W), .EXP_W(EXP_W), .INT_W(INT_W)) i_chk (
  .fltIn (fltIn),
  .intOut(intOut)
);

// File: tb/test_fltToUint.sv
`timescale 1ns/1ps
module test_fltToUint;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] halfIn = '0;
  logic [7:0]  halfOut [5];
  logic [31:0] wideIn = '0;
  logic [31:0] wideOut;

  // Mode index m uses one-hot code 1 << m.
  for (genvar m = 0; m < 5; m++) begin : gMode
    fltToUint #(.FLT_W(16), .EXP_W(5), .INT_W(8), .RMODE(5'(1 << m))) i_fltToUint (
      .fltIn (halfIn),
      .intOut(halfOut[m])
    );
  end

  fltToUint i_fltToUint_wide (
    .fltIn (wideIn),
    .intOut(wideOut)
  );

  function automatic longint model(input logic [63:0] bits, input int fw,
                                   input int ew, input int iw, input int m);
    int     fracW = fw - 1 - ew;
    int     bias  = (1 << (ew - 1)) - 1;
    longint maxv  = (longint'(1) << iw) - 1;
    bit     sgn   = bits[fw-1];
    longint ex    = longint'((bits >> fracW) & ((64'd1 << ew) - 1));
    longint fr    = longint'(bits & ((64'd1 << fracW) - 1));
    longint dflt  = sgn ? 0 : maxv;
    real    v, fl, rem;
    longint q;
    bit     up;
    if (ex == (longint'(1) << ew) - 1) return dflt;
    if (ex == 0) v = real'(fr) * $pow(2.0, real'(1 - bias - fracW));
    else v = (real'(fr) + $pow(2.0, real'(fracW))) * $pow(2.0, real'(ex - bias - fracW));
    fl  = $floor(v);
    rem = v - fl;
    if (fl >= $pow(2.0, real'(iw))) return dflt;
    q = longint'(fl);
    case (m)
      0:       up = (rem > 0.5) || (rem == 0.5 && q[0]);
      1:       up = (rem >= 0.5);
      2:       up = !sgn && (rem > 0.0);
      3:       up = sgn && (rem > 0.0);
      default: up = 1'b0;
    endcase
    q = q + longint'(up);
    if (q > maxv) return dflt;
    if (sgn && q != 0) return 0;
    return q;
  endfunction

  task automatic expectVal(input longint act, input longint exp, input string req,
                           input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic driveHalf(input logic [15:0] h);
    halfIn = h;
    #2;
  endtask

  task automatic driveWide(input logic [31:0] w);
    wideIn = w;
    #2;
  endtask

  // Same expectation for all five rounding rules.
  task automatic halfAll(input logic [15:0] h, input longint exp, input string req);
    driveHalf(h);
    for (int m = 0; m < 5; m++)
      expectVal(longint'(halfOut[m]), exp, req, $sformatf("in=%h mode=%0d", h, m));
  endtask

  task automatic halfMode(input logic [15:0] h, input int m, input longint exp,
                          input string req);
    driveHalf(h);
    expectVal(longint'(halfOut[m]), exp, req, $sformatf("in=%h mode=%0d", h, m));
  endtask

  task automatic wideOne(input logic [31:0] w, input longint exp, input string req);
    driveWide(w);
    expectVal(longint'(wideOut), exp, req, $sformatf("wide in=%h", w));
  endtask

  task automatic tReset;
    halfAll(16'h0000, 0, "R7");
    wideOne(32'h0000_0000, 0, "R7");
  endtask

  task automatic tExact;  // R1
    halfAll(16'h3C00, 1, "R1");
    halfAll(16'h5A40, 200, "R1");
    halfAll(16'h5BF8, 255, "R1");
    wideOne(32'h3F80_0000, 1, "R1");
    wideOne(32'h47F1_2000, 123456, "R1");
    wideOne(32'h4F7F_FFFF, 64'hFFFF_FF00, "R1");
  endtask

  task automatic tInf;  // R2
    halfAll(16'h7C00, 8'hFF, "R2");
    halfAll(16'hFC00, 0, "R2");
    wideOne(32'h7F80_0000, 32'hFFFF_FFFF, "R2");
    wideOne(32'hFF80_0000, 0, "R2");
  endtask

  task automatic tNan;  // R3
    halfAll(16'h7E00, 8'hFF, "R3");
    halfAll(16'h7C01, 8'hFF, "R3");
    halfAll(16'hFE00, 0, "R3");
    wideOne(32'h7FC0_0000, 32'hFFFF_FFFF, "R3");
    wideOne(32'hFFC0_0000, 0, "R3");
  endtask

  task automatic tOverflow;  // R4
    halfAll(16'h5C00, 8'hFF, "R4");
    halfAll(16'h7BFF, 8'hFF, "R4");
    halfMode(16'h5BFC, 0, 8'hFF, "R4");
    halfMode(16'h5BFC, 1, 8'hFF, "R4");
    halfMode(16'h5BFC, 2, 8'hFF, "R4");
    halfMode(16'h5BFC, 3, 255, "R4");
    halfMode(16'h5BFC, 4, 255, "R4");
    wideOne(32'h4F80_0000, 32'hFFFF_FFFF, "R4");
  endtask

  task automatic tNegDefault;  // R5
    halfAll(16'hBC00, 0, "R5");
    halfAll(16'hC1CD, 0, "R5");
    wideOne(32'hC000_0000, 0, "R5");
  endtask

  task automatic tNegSmall;  // R6
    halfAll(16'hB4CD, 0, "R6");
    halfAll(16'hB800, 0, "R6");
    halfAll(16'h8001, 0, "R6");
  endtask

  task automatic tSubnormal;  // R7
    halfAll(16'h8000, 0, "R7");
    for (int m = 0; m < 5; m++) begin
      halfMode(16'h0001, m, (m == 2) ? 1 : 0, "R7");
      halfMode(16'h03FF, m, (m == 2) ? 1 : 0, "R7");
    end
  endtask

  task automatic tTiesEven;  // R8
    halfMode(16'h4100, 0, 2, "R8");
    halfMode(16'h4300, 0, 4, "R8");
    halfMode(16'h3800, 0, 0, "R8");
    halfMode(16'h3E00, 0, 2, "R8");
    halfMode(16'h41CD, 0, 3, "R8");
    halfMode(16'h4033, 0, 2, "R8");
    wideOne(32'h4020_0000, 2, "R8");
    wideOne(32'h4060_0000, 4, "R8");
    wideOne(32'h3F00_0000, 0, "R8");
  endtask

  task automatic tTiesAway;  // R9
    halfMode(16'h4100, 1, 3, "R9");
    halfMode(16'h3800, 1, 1, "R9");
    halfMode(16'h4300, 1, 4, "R9");
    halfMode(16'h4033, 1, 2, "R9");
  endtask

  task automatic tDirected;  // R10
    halfMode(16'h4033, 2, 3, "R10");
    halfMode(16'h34CD, 2, 1, "R10");
    halfMode(16'h4000, 2, 2, "R10");
    halfMode(16'h41CD, 3, 2, "R10");
    halfMode(16'h41CD, 4, 2, "R10");
    halfMode(16'h3800, 4, 0, "R10");
  endtask

  function automatic string tagOf(input logic [15:0] h);
    if (&h[14:10]) return (|h[9:0]) ? "R3" : "R2";
    if (h[15]) return "R5";
    if (h[14:10] == 5'd0) return "R7";
    return "R1";
  endfunction

  task automatic tSweep;
    for (int i = 0; i < 65536; i++) begin
      driveHalf(16'(i));
      for (int m = 0; m < 5; m++)
        expectVal(longint'(halfOut[m]), model(64'(i), 16, 5, 8, m), tagOf(16'(i)),
                  $sformatf("sweep in=%h mode=%0d", 16'(i), m));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst = 1'b0;
    tReset();
    tExact();
    tInf();
    tNan();
    tOverflow();
    tNegDefault();
    tNegSmall();
    tSubnormal();
    tTiesEven();
    tTiesAway();
    tDirected();
    tSweep();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule